// File: doc/BRIEF.md
# I2C Controller Register Block

This block is the byte-wide control and status register file of an I2C master controller. Software reaches it through a simple single-cycle read/write bus with byte offsets 0 to 17. It keeps the mode, control, clock divider, interrupt mask, transfer count, address, status, extended status, extended control and direct line-control registers. Each register applies its own write mask. The status registers clear only selected bits when a one is written to them. The block also owns the interrupt line. The transfer engine and the data queue sit outside. The engine hands in status events and completion or halt events. In return the block gives it the configuration and three one-cycle strobes: start, queue flush and soft reset.

Reads are combinational from the address. Writes take effect at the clock edge on which the write enable is sampled. A soft reset, requested through the extended control register, raises a strobe for one cycle. On the next edge every register returns to its reset value, except the four address registers, which keep their contents.

Top module: `i2cm_csr`

## Requirements
- R1: After reset, control (6), mode (7), status (8), clock divider (12), interrupt mask (13), transfer count (14) and extended control (15) read 0x00. Extended status (9) reads 0x40. Direct control (16) reads 0x0F when both sensed lines are high. `irq` is low.
- R2: A write to mode (7) stores only the bits under 0x3D. A write with bit 6 set clears status bits 4 and 5 at the same edge and pulses `flush_pulse` for the following cycle.
- R3: A write to status (8) clears only the bits set in both the written value and 0x0A. Every other status bit keeps its value.
- R4: An `ev_done` cycle with mode bit 2 and mask bit 0 set, or an `ev_halt` cycle with mode bit 2 and mask bit 3 set, sets status bit 1 and raises `irq` at that edge. Without the matching mask bit the event leaves `irq` and status unchanged.
- R5: `irq` is a held level. A status write with bit 1 set lowers it only while mode bit 2 is set. With mode bit 2 clear, the write clears status bit 1 but leaves `irq` high.
- R6: When an interrupt event and a status write that clears bit 1 fall in the same cycle, the event wins: `irq` and status bit 1 end up set.
- R7: A write to extended status (9) clears the bits set in both the written value and 0x8F. Bits 4 to 6 are not cleared.
- R8: A write to transfer count (14) stores the value masked with 0x77. A write to control (6) stores the value with bit 0 cleared, and bit 0 set pulses `go_pulse` for the following cycle.
- R9: A write to extended control (15) clears the bits set in both the written value and 0xF0. A write with bit 0 set pulses `srst_pulse` in the next cycle, while registers still hold their old values. At the edge after that, all registers take their R1 values and the master (4,5) and slave (10,11) address registers keep theirs.
- R10: Reads of offsets 1, 2, 3, 17 and any offset above 17 return 0x00. A read of offset 0 returns `buf_rdata`. `buf_rd` and `buf_wr` follow reads and writes of offset 0 in the same cycle.
- R11: Direct control (16) reads {4'b0, sda-drive, scl-drive, `sda_in`, `scl_in`}. A write stores bits 3 and 2 as the sda and scl drive levels on `sda_drv` and `scl_drv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| buf_rdata | input | 8 | Head byte of the external data queue |
| buf_wr | output | 1 | Write to offset 0 in this cycle |
| buf_rd | output | 1 | Read of offset 0 in this cycle |
| stat_set | input | 8 | Engine sets these status bits |
| stat_clr | input | 8 | Engine clears these status bits |
| xstat_set | input | 8 | Engine sets these extended status bits |
| xctl_set | input | 8 | Engine sets these extended control bits |
| ev_done | input | 1 | Transfer complete event |
| ev_halt | input | 1 | Halt event |
| scl_in | input | 1 | Sensed clock line |
| sda_in | input | 1 | Sensed data line |
| scl_drv | output | 1 | Clock line drive level |
| sda_drv | output | 1 | Data line drive level |
| ctl_o | output | 8 | Control register |
| mode_o | output | 8 | Mode register |
| clkdiv_o | output | 8 | Clock divider |
| imask_o | output | 8 | Interrupt mask |
| xcnt_o | output | 8 | Transfer count |
| madr_o | output | 16 | Master address {high, low} |
| sadr_o | output | 16 | Slave address {high, low} |
| go_pulse | output | 1 | Start strobe |
| flush_pulse | output | 1 | Queue flush strobe |
| srst_pulse | output | 1 | Soft reset strobe |
| irq | output | 1 | Interrupt level |

## Verification
Two functions can fall in the same cycle: an interrupt being raised by an engine event, and software clearing the interrupt through the status register. The bench provokes this by driving `ev_halt` in the very cycle of a status write of 0x02 with interrupts enabled. After the edge it requires `irq` and status bit 1 to be set. A further write then confirms that the clear still works once the event is gone.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;

  localparam int NREG = 18;

  localparam int OFF_BUF    = 0;
  localparam int OFF_MADR_L = 4;
  localparam int OFF_MADR_H = 5;
  localparam int OFF_CTL    = 6;
  localparam int OFF_MODE   = 7;
  localparam int OFF_STAT   = 8;
  localparam int OFF_XSTAT  = 9;
  localparam int OFF_SADR_L = 10;
  localparam int OFF_SADR_H = 11;
  localparam int OFF_CLKDIV = 12;
  localparam int OFF_IMASK  = 13;
  localparam int OFF_XCNT   = 14;
  localparam int OFF_XCTL   = 15;
  localparam int OFF_DIRECT = 16;

  localparam logic [7:0] MODE_KEEP  = 8'h3D;
  localparam logic [7:0] CTL_KEEP   = 8'hFE;
  localparam logic [7:0] XCNT_KEEP  = 8'h77;
  localparam logic [7:0] STAT_W1C   = 8'h0A;
  localparam logic [7:0] XSTAT_W1C  = 8'h8F;
  localparam logic [7:0] XCTL_W1C   = 8'hF0;
  localparam logic [7:0] XSTAT_RST  = 8'h40;
  localparam logic [7:0] FLUSH_CLR  = 8'h30;

  localparam int MODE_EINT  = 2;
  localparam int MODE_FLUSH = 6;
  localparam int MASK_DONE  = 0;
  localparam int MASK_HALT  = 3;
  localparam int STAT_IRQ   = 1;
  localparam int CTL_GO     = 0;
  localparam int XCTL_SRST  = 0;

  function automatic logic [7:0] keep_bits(input logic [7:0] v, input logic [7:0] m);
    return v & m;
  endfunction

  function automatic logic [7:0] w1c(input logic [7:0] cur, input logic [7:0] wv,
                                     input logic [7:0] m);
    return cur & ~(wv & m);
  endfunction

endpackage

// File: rtl/i2cm_csr_stat.sv
module i2cm_csr_stat
  import i2cm_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       eint,
  input  logic       msk_done,
  input  logic       msk_halt,
  input  logic       ev_done,
  input  logic       ev_halt,
  input  logic       flush,
  input  logic [7:0] stat_set,
  input  logic [7:0] stat_clr,
  output logic [7:0] stat_q,
  output logic       irq
);

  logic       raise;
  logic       clr_line;
  logic [7:0] stat_n;

  assign raise    = eint && ((ev_done && msk_done) || (ev_halt && msk_halt));
  assign clr_line = wr_stat && wdata[STAT_IRQ] && eint;

  always_comb begin
    stat_n = stat_q;
    if (wr_stat) stat_n = w1c(stat_n, wdata, STAT_W1C);
    if (flush)   stat_n = stat_n & ~FLUSH_CLR;
    stat_n = (stat_n & ~stat_clr) | stat_set;
    if (raise)   stat_n[STAT_IRQ] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else if (srst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_n;
      if (raise)         irq <= 1'b1;
      else if (clr_line) irq <= 1'b0;
    end
  end

  assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && !srst) |=> (irq && stat_q[STAT_IRQ]));

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_line && !raise && !srst) |=> !irq);

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_line && !srst) |=> irq);

  assert_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && clr_line && !srst) |=> (irq && stat_q[STAT_IRQ]));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[3] && !stat_set[3] && !srst) |=> !stat_q[3]);

endmodule

// File: rtl/i2cm_csr_ext.sv
module i2cm_csr_ext
  import i2cm_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_xstat,
  input  logic       wr_xctl,
  input  logic [7:0] wdata,
  input  logic [7:0] xstat_set,
  input  logic [7:0] xctl_set,
  output logic [7:0] xstat_q,
  output logic [7:0] xctl_q,
  output logic       soft_rst
);

  logic [7:0] xstat_n;
  logic [7:0] xctl_n;

  always_comb begin
    xstat_n = wr_xstat ? w1c(xstat_q, wdata, XSTAT_W1C) : xstat_q;
    xstat_n = xstat_n | xstat_set;
    xctl_n  = wr_xctl ? w1c(xctl_q, wdata, XCTL_W1C) : xctl_q;
    xctl_n  = xctl_n | xctl_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xstat_q  <= XSTAT_RST;
      xctl_q   <= '0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= wr_xctl && wdata[XCTL_SRST] && !soft_rst;
      if (soft_rst) begin
        xstat_q <= XSTAT_RST;
        xctl_q  <= '0;
      end else begin
        xstat_q <= xstat_n;
        xctl_q  <= xctl_n;
      end
    end
  end

  assert_srst_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (xstat_q == XSTAT_RST && xctl_q == 8'h00));

  assert_srst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_xctl && wdata[XCTL_SRST] && !soft_rst) |=> soft_rst);

  assert_xstat_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_xstat && !soft_rst && xstat_set == 8'h00)
      |=> xstat_q == ($past(xstat_q) & ~($past(wdata) & XSTAT_W1C)));

endmodule

// File: rtl/i2cm_csr_rdmux.sv
module i2cm_csr_rdmux
  import i2cm_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NREG-1:0][7:0]  view,
  output logic [7:0]            rdata
);

  always_comb begin
    rdata = 8'h00;
    for (int k = 0; k < NREG; k++) begin
      if (addr == ADDR_W'(k)) rdata = view[k];
    end
  end

endmodule

// File: rtl/i2cm_csr.sv
module i2cm_csr
  import i2cm_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr,
  output logic              buf_rd,
  input  logic [7:0]        stat_set,
  input  logic [7:0]        stat_clr,
  input  logic [7:0]        xstat_set,
  input  logic [7:0]        xctl_set,
  input  logic              ev_done,
  input  logic              ev_halt,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drv,
  output logic              sda_drv,
  output logic [7:0]        ctl_o,
  output logic [7:0]        mode_o,
  output logic [7:0]        clkdiv_o,
  output logic [7:0]        imask_o,
  output logic [7:0]        xcnt_o,
  output logic [15:0]       madr_o,
  output logic [15:0]       sadr_o,
  output logic              go_pulse,
  output logic              flush_pulse,
  output logic              srst_pulse,
  output logic              irq
);

  logic [NREG-1:0]      wsel;
  logic [NREG-1:0][7:0] view;
  logic [7:0] ctl_q, mode_q, clkdiv_q, imask_q, xcnt_q;
  logic [7:0] madr_l, madr_h, sadr_l, sadr_h;
  logic [1:0] dir_q;
  logic [7:0] stat_q, xstat_q, xctl_q;
  logic       soft_rst;
  logic       flush_now;

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign wsel[k] = wr_en && (addr == ADDR_W'(k));
  end

  assign flush_now = wsel[OFF_MODE] && wdata[MODE_FLUSH];
  assign buf_wr    = wsel[OFF_BUF];
  assign buf_rd    = rd_en && (addr == ADDR_W'(OFF_BUF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      madr_l <= '0; madr_h <= '0; sadr_l <= '0; sadr_h <= '0;
    end else begin
      if (wsel[OFF_MADR_L]) madr_l <= wdata;
      if (wsel[OFF_MADR_H]) madr_h <= wdata;
      if (wsel[OFF_SADR_L]) sadr_l <= wdata;
      if (wsel[OFF_SADR_H]) sadr_h <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; mode_q <= '0; clkdiv_q <= '0; imask_q <= '0; xcnt_q <= '0;
      dir_q <= 2'b11; go_pulse <= 1'b0; flush_pulse <= 1'b0;
    end else if (soft_rst) begin
      ctl_q <= '0; mode_q <= '0; clkdiv_q <= '0; imask_q <= '0; xcnt_q <= '0;
      dir_q <= 2'b11; go_pulse <= 1'b0; flush_pulse <= 1'b0;
    end else begin
      go_pulse    <= wsel[OFF_CTL] && wdata[CTL_GO];
      flush_pulse <= flush_now;
      if (wsel[OFF_CTL])    ctl_q    <= keep_bits(wdata, CTL_KEEP);
      if (wsel[OFF_MODE])   mode_q   <= keep_bits(wdata, MODE_KEEP);
      if (wsel[OFF_CLKDIV]) clkdiv_q <= wdata;
      if (wsel[OFF_IMASK])  imask_q  <= wdata;
      if (wsel[OFF_XCNT])   xcnt_q   <= keep_bits(wdata, XCNT_KEEP);
      if (wsel[OFF_DIRECT]) dir_q    <= wdata[3:2];
    end
  end

  i2cm_csr_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (soft_rst),
    .wr_stat  (wsel[OFF_STAT]),
    .wdata    (wdata),
    .eint     (mode_q[MODE_EINT]),
    .msk_done (imask_q[MASK_DONE]),
    .msk_halt (imask_q[MASK_HALT]),
    .ev_done  (ev_done),
    .ev_halt  (ev_halt),
    .flush    (flush_now),
    .stat_set (stat_set),
    .stat_clr (stat_clr),
    .stat_q   (stat_q),
    .irq      (irq)
  );

  i2cm_csr_ext u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_xstat  (wsel[OFF_XSTAT]),
    .wr_xctl   (wsel[OFF_XCTL]),
    .wdata     (wdata),
    .xstat_set (xstat_set),
    .xctl_set  (xctl_set),
    .xstat_q   (xstat_q),
    .xctl_q    (xctl_q),
    .soft_rst  (soft_rst)
  );

  always_comb begin
    view             = '0;
    view[OFF_BUF]    = buf_rdata;
    view[OFF_MADR_L] = madr_l;
    view[OFF_MADR_H] = madr_h;
    view[OFF_CTL]    = ctl_q;
    view[OFF_MODE]   = mode_q;
    view[OFF_STAT]   = stat_q;
    view[OFF_XSTAT]  = xstat_q;
    view[OFF_SADR_L] = sadr_l;
    view[OFF_SADR_H] = sadr_h;
    view[OFF_CLKDIV] = clkdiv_q;
    view[OFF_IMASK]  = imask_q;
    view[OFF_XCNT]   = xcnt_q;
    view[OFF_XCTL]   = xctl_q;
    view[OFF_DIRECT] = {4'b0000, dir_q, sda_in, scl_in};
  end

  i2cm_csr_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .addr  (addr),
    .view  (view),
    .rdata (rdata)
  );

  assign sda_drv    = dir_q[1];
  assign scl_drv    = dir_q[0];
  assign ctl_o      = ctl_q;
  assign mode_o     = mode_q;
  assign clkdiv_o   = clkdiv_q;
  assign imask_o    = imask_q;
  assign xcnt_o     = xcnt_q;
  assign madr_o     = {madr_h, madr_l};
  assign sadr_o     = {sadr_h, sadr_l};
  assign srst_pulse = soft_rst;

  assert_mode_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel[OFF_MODE] && !soft_rst) |=> mode_o == ($past(wdata) & MODE_KEEP));

  assert_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_now && !soft_rst) |=> flush_pulse);

  assert_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel[OFF_CTL] && wdata[CTL_GO] && !soft_rst) |=> (go_pulse && !ctl_o[CTL_GO]));

  assert_addr_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (madr_o == $past(madr_o) && sadr_o == $past(sadr_o)));

  assert_srst_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_o == 8'h00 && ctl_o == 8'h00 && !irq));

endmodule

// File: tb/tb_i2cm_csr.sv
module tb_i2cm_csr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata, buf_rdata = 8'h9C;
  logic        buf_wr, buf_rd;
  logic [7:0]  stat_set = '0, stat_clr = '0, xstat_set = '0, xctl_set = '0;
  logic        ev_done = 1'b0, ev_halt = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic        scl_drv, sda_drv, go_pulse, flush_pulse, srst_pulse, irq;
  logic [7:0]  ctl_o, mode_o, clkdiv_o, imask_o, xcnt_o;
  logic [15:0] madr_o, sadr_o;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  i2cm_csr dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d,
                    input logic done = 1'b0, input logic halt = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; ev_done = done; ev_halt = halt;
    @(negedge clk);
    wr_en = 1'b0; ev_done = 1'b0; ev_halt = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ss, input logic [7:0] sc,
                       input logic [7:0] xs, input logic [7:0] xc,
                       input logic done, input logic halt);
    @(negedge clk);
    stat_set = ss; stat_clr = sc; xstat_set = xs; xctl_set = xc;
    ev_done = done; ev_halt = halt;
    @(negedge clk);
    stat_set = '0; stat_clr = '0; xstat_set = '0; xctl_set = '0;
    ev_done = 1'b0; ev_halt = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, {24'b0, d}, {24'b0, exp});
  endtask

  // {offset, write value, expected read-back}
  localparam logic [23:0] VEC [12] = '{
    {8'd7,  8'hFF, 8'h3D},  // R2 mode mask
    {8'd14, 8'hFF, 8'h77},  // R8 transfer count mask
    {8'd6,  8'hFF, 8'hFE},  // R8 control drops bit 0
    {8'd12, 8'hA5, 8'hA5},
    {8'd13, 8'h0F, 8'h0F},
    {8'd4,  8'h3C, 8'h3C},
    {8'd5,  8'h12, 8'h12},
    {8'd10, 8'h55, 8'h55},
    {8'd11, 8'hAA, 8'hAA},
    {8'd17, 8'hFF, 8'h00},  // R10 undefined
    {8'd3,  8'hFF, 8'h00},  // R10 undefined
    {8'd16, 8'h00, 8'h03}   // R11 drives low, lines high
  };

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rchk("R1 ctl",    6,  8'h00);
    rchk("R1 mode",   7,  8'h00);
    rchk("R1 stat",   8,  8'h00);
    rchk("R1 xstat",  9,  8'h40);
    rchk("R1 clkdiv", 12, 8'h00);
    rchk("R1 imask",  13, 8'h00);
    rchk("R1 xcnt",   14, 8'h00);
    rchk("R1 xctl",   15, 8'h00);
    rchk("R1 direct", 16, 8'h0F);
    chk("R1 irq", {31'b0, irq}, 32'd0);

    // table walk
    foreach (VEC[i]) begin
      wr(VEC[i][20:16], VEC[i][15:8]);
      rchk($sformatf("table entry %0d offset %0d", i, VEC[i][23:16]),
           VEC[i][20:16], VEC[i][7:0]);
    end
    chk("R11 scl_drv low", {31'b0, scl_drv}, 32'd0);
    chk("R11 sda_drv low", {31'b0, sda_drv}, 32'd0);
    chk("R9 madr value", {16'b0, madr_o}, 32'h123C);

    // R8 start strobe
    wr(6, 8'h01);
    chk("R8 go_pulse", {31'b0, go_pulse}, 32'd1);
    rchk("R8 ctl bit0 not stored", 6, 8'h00);
    @(negedge clk);
    chk("R8 go_pulse one cycle", {31'b0, go_pulse}, 32'd0);

    // R3 status write-one-to-clear
    pulse(8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    rchk("R3 stat set", 8, 8'hFF);
    wr(8, 8'hFF);
    rchk("R3 stat w1c", 8, 8'hF5);

    // R2 flush
    wr(7, 8'h40);
    chk("R2 flush_pulse", {31'b0, flush_pulse}, 32'd1);
    rchk("R2 mode after flush", 7, 8'h00);
    rchk("R2 flush clears bits 4,5", 8, 8'hC5);
    pulse(8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0);
    rchk("R3 engine clear", 8, 8'h00);

    // R4 / R5 interrupt
    wr(7, 8'h04);
    pulse(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R4 halt raises irq", {31'b0, irq}, 32'd1);
    rchk("R4 stat bit1", 8, 8'h02);
    wr(8, 8'h02);
    chk("R5 clear with eint", {31'b0, irq}, 32'd0);
    rchk("R5 stat cleared", 8, 8'h00);
    wr(13, 8'h08);
    pulse(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R4 masked done no irq", {31'b0, irq}, 32'd0);
    rchk("R4 masked done stat", 8, 8'h00);
    pulse(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R4 halt raises again", {31'b0, irq}, 32'd1);
    wr(7, 8'h00);
    wr(8, 8'h02);
    chk("R5 irq held without eint", {31'b0, irq}, 32'd1);
    rchk("R5 stat bit cleared anyway", 8, 8'h00);

    // R6 collision
    wr(7, 8'h04);
    wr(8, 8'h02, 1'b0, 1'b1);
    chk("R6 raise wins irq", {31'b0, irq}, 32'd1);
    rchk("R6 raise wins stat", 8, 8'h02);
    wr(8, 8'h02);
    chk("R6 later clear", {31'b0, irq}, 32'd0);

    // R7 extended status
    pulse(8'h00, 8'h00, 8'h8F, 8'h00, 1'b0, 1'b0);
    rchk("R7 xstat set", 9, 8'hCF);
    wr(9, 8'hFF);
    rchk("R7 xstat w1c keeps bit6", 9, 8'h40);

    // R9 extended control clear
    pulse(8'h00, 8'h00, 8'h00, 8'hF0, 1'b0, 1'b0);
    rchk("R9 xctl set", 15, 8'hF0);
    wr(15, 8'h30);
    rchk("R9 xctl w1c", 15, 8'hC0);
    chk("R9 no srst without bit0", {31'b0, srst_pulse}, 32'd0);

    // R10 buffer and undefined offsets
    rchk("R10 offset 0", 0, 8'h9C);
    addr = 0; rd_en = 1'b1; #1;
    chk("R10 buf_rd", {31'b0, buf_rd}, 32'd1);
    rd_en = 1'b0;
    rchk("R10 offset 1", 1, 8'h00);
    rchk("R10 offset 20", 20, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; addr = 0; wdata = 8'h11; #1;
    chk("R10 buf_wr", {31'b0, buf_wr}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;

    // R11 direct control
    scl_in = 1'b0;
    wr(16, 8'h0C);
    rchk("R11 direct read", 16, 8'h0E);
    chk("R11 scl_drv high", {31'b0, scl_drv}, 32'd1);
    chk("R11 sda_drv high", {31'b0, sda_drv}, 32'd1);
    scl_in = 1'b1;

    // R9 soft reset
    wr(13, 8'h01);
    pulse(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R9 irq before srst", {31'b0, irq}, 32'd1);
    wr(15, 8'h01);
    chk("R9 srst_pulse", {31'b0, srst_pulse}, 32'd1);
    rchk("R9 old clkdiv during pulse", 12, 8'hA5);
    @(negedge clk);
    chk("R9 srst_pulse one cycle", {31'b0, srst_pulse}, 32'd0);
    rchk("R9 clkdiv reset", 12, 8'h00);
    rchk("R9 mode reset", 7, 8'h00);
    rchk("R9 imask reset", 13, 8'h00);
    rchk("R9 xcnt reset", 14, 8'h00);
    rchk("R9 xstat reset", 9, 8'h40);
    rchk("R9 xctl reset", 15, 8'h00);
    rchk("R9 direct reset", 16, 8'h0F);
    chk("R9 irq reset", {31'b0, irq}, 32'd0);
    chk("R9 madr kept", {16'b0, madr_o}, 32'h123C);
    chk("R9 sadr kept", {16'b0, sadr_o}, 32'hAA55);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule